// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the master side of a read-only link to an external eight-input serial converter. When a start request arrives and the link is idle, the controller pulls chip select low. That edge makes the converter hold its input and begin a conversion. The controller then issues exactly sixteen serial clock cycles, taken from the system clock through a run-time integer divider, and shifts in the converter's reply on the data line.

Each reply carries a 4-bit channel tag first and a 12-bit result after it, each most significant bit first. Once the last bit has been taken, the controller raises chip select and presents the tag together with a 16-bit result on a parallel port, marked by a single-cycle valid strobe. Voltage results are straight binary and are zero-extended. The temperature result is two's complement and is sign-extended; the tag that marks it is a configuration input. A minimum quiet time with chip select high, also set at run time, separates one frame from the next.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is high and in the cycle after it, cs_n_o = 1, sclk_o = 1, busy_o = 0, valid_o = 0, tag_o = 0 and result_o = 0.
- R2: A start_i seen high at a clock edge while idle (and with the quiet time expired) drives cs_n_o low and busy_o high from that edge.
- R3: With D = div_i, where any value below 2 is treated as 2, sclk_o stays low for floor(D/2) system cycles and high for D - floor(D/2) cycles. After chip select falls, sclk_o first stays high for one high-phase length. The divider is latched when a start is accepted.
- R4: Each frame has exactly 16 falling edges of sclk_o. sdata_i is sampled at the system clock edge that raises sclk_o.
- R5: The first four sampled bits, MSB first, form tag_o[3:0]. The remaining twelve, MSB first, form result bits 11 down to 0.
- R6: When the tag differs from temp_tag_i, result_o[15:12] = 0.
- R7: When the tag equals temp_tag_i, result_o[15:12] repeat result bit 11.
- R8: After the 16th rising edge of sclk_o, one high-phase length passes. Then, on a single edge, cs_n_o rises, busy_o falls and valid_o goes high for exactly one cycle. tag_o and result_o hold their values until the next valid.
- R9: start_i has no effect while a frame is in progress. The frame length and the chip select timing stay unchanged.
- R10: After cs_n_o rises, start_i is ignored on the next quiet_i clock edges, so chip select stays high for at least quiet_i + 1 cycles.
- R11: sclk_o is high whenever cs_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to read one frame |
| div_i | input | 8 | System cycles per serial clock period (minimum 2) |
| quiet_i | input | 8 | Edges after a frame during which starts are ignored |
| temp_tag_i | input | 4 | Tag value that marks the temperature result |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | One-cycle strobe: new tag and result |
| tag_o | output | 4 | Channel tag of the last frame |
| result_o | output | 16 | Extended 12-bit result of the last frame |

## Verification
The hardest case to reach from the ports is a start request that lands exactly when the quiet counter expires. Only an edge-accurate sense of when the gap ends can tell an accepted start from an ignored one. The stimulus therefore holds start_i high across two frames, which forces the second frame to begin on the first edge the quiet rule allows. It also pokes start_i in the middle of a frame. The behavioural model rebuilds the whole serial clock schedule from the divider and checks the odd-divider case, where the high phase is longer than the low phase, as well as values below 2 that are clamped.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_LOW  = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

endpackage

// File: rtl/adcr_seq.sv
module adcr_seq
  import adcr_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int QUIET_W = 8,
  parameter int NBITS   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [QUIET_W-1:0] quiet_i,
  output logic               cs_n_o,
  output logic               sclk_o,
  output logic               busy_o,
  output logic               sample_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(NBITS + 1);

  phase_t             phase;
  logic [DIV_W-1:0]   cnt;
  logic [DIV_W-1:0]   lo_r, hi_r;
  logic [DIV_W-1:0]   div_eff, lo_w, hi_w;
  logic [CNT_W-1:0]   nbit;
  logic [QUIET_W-1:0] qcnt;
  logic               cs_n_q, sclk_q, busy_q;

  always_comb begin
    div_eff = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
    lo_w    = div_eff >> 1;
    hi_w    = div_eff - lo_w;
  end

  assign sample_o = (phase == PH_LOW) && (cnt == '0);
  assign done_o   = (phase == PH_HIGH) && (cnt == '0) && (nbit == CNT_W'(NBITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      lo_r   <= DIV_W'(1);
      hi_r   <= DIV_W'(1);
      nbit   <= '0;
      qcnt   <= '0;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (qcnt != '0) begin
            qcnt <= qcnt - 1'b1;
          end else if (start_i) begin
            cs_n_q <= 1'b0;
            busy_q <= 1'b1;
            sclk_q <= 1'b1;
            lo_r   <= lo_w;
            hi_r   <= hi_w;
            cnt    <= hi_w - 1'b1;
            nbit   <= '0;
            phase  <= PH_LEAD;
          end
        end
        PH_LEAD: begin
          if (cnt == '0) begin
            sclk_q <= 1'b0;
            cnt    <= lo_r - 1'b1;
            phase  <= PH_LOW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt == '0) begin
            sclk_q <= 1'b1;
            nbit   <= nbit + 1'b1;
            cnt    <= hi_r - 1'b1;
            phase  <= PH_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt == '0) begin
            if (nbit == CNT_W'(NBITS)) begin
              cs_n_q <= 1'b1;
              busy_q <= 1'b0;
              qcnt   <= quiet_i;
              phase  <= PH_IDLE;
            end else begin
              sclk_q <= 1'b0;
              cnt    <= lo_r - 1'b1;
              phase  <= PH_LOW;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign cs_n_o = cs_n_q;
  assign sclk_o = sclk_q;
  assign busy_o = busy_q;

endmodule

// File: rtl/adcr_shift.sv
module adcr_shift #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_i,
  input  logic             sdata_i,
  output logic [NBITS-1:0] word_o
);
  logic [NBITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else if (sample_i) begin
      sh <= {sh[NBITS-2:0], sdata_i};
    end
  end

  assign word_o = sh;

endmodule

// File: rtl/adcr_decode.sv
module adcr_decode #(
  parameter int TAG_W = 4,
  parameter int RES_W = 12,
  parameter int OUT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   done_i,
  input  logic [TAG_W+RES_W-1:0] word_i,
  input  logic [TAG_W-1:0]       temp_tag_i,
  output logic                   valid_o,
  output logic [TAG_W-1:0]       tag_o,
  output logic [OUT_W-1:0]       result_o
);
  localparam int EXT_W = OUT_W - RES_W;

  logic [TAG_W-1:0] tag_w;
  logic [RES_W-1:0] val_w;
  logic             is_temp;
  logic [OUT_W-1:0] ext_w;

  assign tag_w   = word_i[TAG_W+RES_W-1 -: TAG_W];
  assign val_w   = word_i[RES_W-1:0];
  assign is_temp = (tag_w == temp_tag_i);

  generate
    if (EXT_W > 0) begin : g_ext
      assign ext_w = {{EXT_W{is_temp & val_w[RES_W-1]}}, val_w};
    end else begin : g_noext
      assign ext_w = val_w[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      tag_o    <= '0;
      result_o <= '0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        tag_o    <= tag_w;
        result_o <= ext_w;
      end
    end
  end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DIV_W   = 8,
  parameter int QUIET_W = 8,
  parameter int TAG_W   = 4,
  parameter int RES_W   = 12,
  parameter int OUT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [QUIET_W-1:0] quiet_i,
  input  logic [TAG_W-1:0]   temp_tag_i,
  input  logic               sdata_i,
  output logic               cs_n_o,
  output logic               sclk_o,
  output logic               busy_o,
  output logic               valid_o,
  output logic [TAG_W-1:0]   tag_o,
  output logic [OUT_W-1:0]   result_o
);
  localparam int NBITS = TAG_W + RES_W;

  logic             sample_w, done_w;
  logic [NBITS-1:0] word_w;

  adcr_seq #(
    .DIV_W  (DIV_W),
    .QUIET_W(QUIET_W),
    .NBITS  (NBITS)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .div_i   (div_i),
    .quiet_i (quiet_i),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .busy_o  (busy_o),
    .sample_o(sample_w),
    .done_o  (done_w)
  );

  adcr_shift #(
    .NBITS(NBITS)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sample_i(sample_w),
    .sdata_i (sdata_i),
    .word_o  (word_w)
  );

  adcr_decode #(
    .TAG_W(TAG_W),
    .RES_W(RES_W),
    .OUT_W(OUT_W)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .done_i    (done_w),
    .word_i    (word_w),
    .temp_tag_i(temp_tag_i),
    .valid_o   (valid_o),
    .tag_o     (tag_o),
    .result_o  (result_o)
  );

endmodule

// File: rtl/adcr_chk.sv
module adcr_chk #(
  parameter int TAG_W = 4,
  parameter int RES_W = 12,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [TAG_W-1:0] temp_tag_i,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic             busy_o,
  input logic             valid_o,
  input logic [TAG_W-1:0] tag_o,
  input logic [OUT_W-1:0] result_o
);

  p_idle_clock_high_r11: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> sclk_o);

  p_clock_falls_framed_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> !cs_n_o);

  p_select_needs_start_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> ($past(start_i) && busy_o));

  p_valid_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  p_valid_closes_frame_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (cs_n_o && !busy_o));

  p_result_held_r8: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(result_o) && $stable(tag_o)));

  p_voltage_zero_ext_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && (tag_o != temp_tag_i)) |-> ((result_o >> RES_W) == '0));

endmodule

bind adc_frame_reader adcr_chk #(
  .TAG_W(TAG_W),
  .RES_W(RES_W),
  .OUT_W(OUT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .temp_tag_i(temp_tag_i),
  .cs_n_o    (cs_n_o),
  .sclk_o    (sclk_o),
  .busy_o    (busy_o),
  .valid_o   (valid_o),
  .tag_o     (tag_o),
  .result_o  (result_o)
);

// File: tb/sim_adc_frame_reader.sv
`timescale 1ns/1ps
module sim_adc_frame_reader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  div_i = 8'd2;
  logic [7:0]  quiet_i = 8'd0;
  logic [3:0]  temp_tag_i = 4'd8;
  logic        sdata_i = 1'b0;
  logic        cs_n_o, sclk_o, busy_o, valid_o;
  logic [3:0]  tag_o;
  logic [15:0] result_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  adc_frame_reader u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .div_i(div_i), .quiet_i(quiet_i),
    .temp_tag_i(temp_tag_i), .sdata_i(sdata_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .busy_o(busy_o), .valid_o(valid_o), .tag_o(tag_o), .result_o(result_o)
  );

  // words the converter model will send, in order
  logic [15:0] wq[$];

  function automatic logic [15:0] expect_res(input logic [15:0] w, input logic [3:0] tt);
    if (w[15:12] == tt) return {{4{w[11]}}, w[11:0]};
    return {4'h0, w[11:0]};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural schedule model ----------------
  int j = -1, ql = 0, lo_n = 1, hi_n = 1, fin = 0;
  logic [15:0] cur_w = '0;
  logic e_cs = 1, e_sclk = 1, e_busy = 0, e_valid = 0;
  logic [3:0]  e_tag = '0;
  logic [15:0] e_res = '0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      j = -1; ql = 0;
      e_cs = 1; e_sclk = 1; e_busy = 0; e_valid = 0; e_tag = '0; e_res = '0;
    end else begin
      e_valid = 0;
      if (j >= 0) begin
        j++;
        if (j == fin) begin
          e_cs = 1; e_sclk = 1; e_busy = 0; e_valid = 1;
          e_tag = cur_w[15:12];
          e_res = expect_res(cur_w, temp_tag_i);
          j = -1; ql = int'(quiet_i);
        end else if (j < hi_n) begin
          e_sclk = 1;
        end else begin
          e_sclk = (((j - hi_n) % (lo_n + hi_n)) < lo_n) ? 1'b0 : 1'b1;
        end
      end else if (ql > 0) begin
        ql--;
      end else if (start_i) begin
        int d;
        d = (int'(div_i) < 2) ? 2 : int'(div_i);
        lo_n = d / 2; hi_n = d - lo_n;
        fin = hi_n + 16 * d;
        cur_w = (wq.size() > 0) ? wq[0] : 16'h0;
        j = 0; e_cs = 0; e_busy = 1; e_sclk = 1;
      end
    end
  end

  // ---------------- converter model (changes data on sclk fall) ----------------
  logic        p_cs = 1, p_sclk = 1;
  logic [15:0] dev_sh = '0;
  int          dev_n = 0;
  int          falls = 0;

  always @(negedge clk) begin
    if (cs_n_o) begin
      sdata_i <= 1'b0;
    end else begin
      if (p_cs) begin
        dev_sh = (wq.size() > 0) ? wq.pop_front() : 16'h0;
        dev_n = 0;
        falls = 0;
      end
      if (p_sclk && !sclk_o) begin
        sdata_i <= dev_sh[15 - (dev_n % 16)];
        dev_n++;
        falls++;
      end
    end
    p_cs = cs_n_o;
    p_sclk = sclk_o;
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst) begin
      check((j < 0) ? "R10" : (start_i ? "R9" : "R2"), "cs_n_o", cs_n_o, e_cs);
      check("R3", "sclk_o", sclk_o, e_sclk);
      check("R8", "busy_o", busy_o, e_busy);
      check("R8", "valid_o", valid_o, e_valid);
      check("R5", "tag_o", tag_o, e_tag);
      check((e_tag == temp_tag_i) ? "R7" : "R6", "result_o", result_o, e_res);
      if (cs_n_o) check("R11", "sclk_o idle", sclk_o, 1);
      if (valid_o) check("R4", "sclk falls per frame", falls, 16);
    end
  end

  // ---------------- stimulus ----------------
  task automatic frame(input logic [15:0] w, input int d, input int q,
                       input logic [3:0] tt, input bit poke);
    @(negedge clk);
    div_i = d[7:0]; quiet_i = q[7:0]; temp_tag_i = tt;
    wq.push_back(w);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (poke) begin
      // R9: start pulses during the frame must be ignored
      repeat (5) @(negedge clk);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    while (!valid_o) @(negedge clk);
    repeat (q + 3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "cs_n_o", cs_n_o, 1);
    check("R1", "sclk_o", sclk_o, 1);
    check("R1", "busy_o", busy_o, 0);
    check("R1", "valid_o", valid_o, 0);
    check("R1", "result_o", result_o, 0);
    rst = 0;
    @(negedge clk);
    check("R1", "tag_o", tag_o, 0);

    frame(16'h3ABC, 2, 0, 4'd8, 0);   // R6 voltage, fastest divider
    frame(16'h8F80, 5, 2, 4'd8, 0);   // R7 negative temperature, odd divider R3
    frame(16'h87FF, 4, 1, 4'd8, 1);   // R7 positive temperature, R9 poke
    frame(16'h0000, 0, 0, 4'd8, 0);   // R3 divider clamp (0)
    frame(16'h5FFF, 1, 0, 4'd8, 0);   // R3 divider clamp (1), R6
    frame(16'hF800, 3, 0, 4'hF, 0);   // R7 with another temperature tag
    frame(16'h8800, 3, 0, 4'hF, 1);   // R6 tag 8 is voltage now

    // R10: start held high across two frames -> second starts at quiet expiry
    @(negedge clk);
    div_i = 8'd2; quiet_i = 8'd5; temp_tag_i = 4'd8;
    wq.push_back(16'h1123);
    wq.push_back(16'h7456);
    start_i = 1;
    while (!valid_o) @(negedge clk);
    @(negedge clk);
    while (!valid_o) @(negedge clk);
    start_i = 0;
    repeat (10) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule